// File: doc/BRIEF.md
# Five-Decade Mode-Selectable BCD Tally Counter

This block counts rising edges on an asynchronous count input with a chain of five binary-coded-decimal decades, from units up to ten-thousands. The count input is brought into the system clock domain by a two-flop synchroniser. A rising-edge detector then turns each input edge into a single-cycle step. All decades update on the same system clock edge, and a carry propagates through the chain within that cycle. A downstream display scanner reads the packed decade values continuously. No flow control is needed for that path: the values are a plain, always-valid status bus with no back-pressure.

Two mode bits set how the first decade behaves and where it hands its carry to the second decade. The modes give a plain five-digit counter, a direct-drive test mode, a four-digit counter with round-off, and a four-digit counter with a half-unit first digit.

A synchronous clear input zeroes every decade. The carry output serves two purposes. It marks the count period that follows a full wrap of the chain, so that counters can be cascaded, and it also stays high for as long as the clear input is held.

Top module: `bcd_tally5`

## Requirements
- R1: After `rst_n` is released, or on the clock edge after `clr` is sampled high, every field of `digit_val` reads 0. Decade i occupies bits [4i+3:4i], and decade 0 is the units decade.
- R2: Each rising edge of `count_in` advances the chain by exactly one step, however long the input stays high. While no step occurs, decades 1 and above hold their value.
- R3: When `mode_sel` is 2'b00 (bit 1 is mode A, bit 0 is mode B), the units decade counts 0 to 9 and shows its true value. It carries into decade 1 on its 9-to-0 transition.
- R4: Every decade from decade 1 upward stays within 0 to 9 and carries into the next decade on its own 9-to-0 transition, in every mode.
- R5: When `mode_sel` is 2'b01 (test mode), the units field reads 0 and every step advances decade 1 directly.
- R6: When `mode_sel` is 2'b11 (round-off), the units field reads 0 while its hidden count keeps running 0 to 9. Decade 1 advances on the hidden count's 4-to-5 transition.
- R7: When `mode_sel` is 2'b10 (half-unit), the units field reads 5 while its hidden count is 3 to 7 and reads 0 otherwise. Decade 1 advances on the hidden 7-to-8 transition.
- R8: When the top decade wraps from 9 to 0, `carry_out` rises on the same edge that shows decades 1 and above all at zero. It stays high until the next step and then falls.
- R9: `carry_out` is high in every cycle in which `clr` is high.
- R10: A step that arrives in the same cycle as `clr` is discarded, and the decades read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clr | input | 1 | Synchronous master clear of all decades, active high |
| count_in | input | 1 | Asynchronous count input; each rising edge is one count |
| mode_sel | input | 2 | Bit 1 = mode A, bit 0 = mode B; selects first-decade behaviour |
| digit_val | output | 20 | Packed decade values, decade i at [4i+3:4i] |
| carry_out | output | 1 | Chain-wrap marker for one count period; also high during clear |

## Verification
A master clear and a count step can land on the same clock edge. The bench provokes this by raising `count_in` one cycle before `clr`, so the detected step reaches the decades while the clear is sampled. It then judges that the decades read zero, that `carry_out` is high during the clear, and that no late increment appears once the clear drops. A chain wrap and a carry-out release also meet at a step boundary. The full wrap is reached quickly in test mode, and `carry_out` is sampled before and after the next step.

// File: rtl/bcd_tally_pkg.sv
package bcd_tally_pkg;

  localparam int unsigned DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

  typedef enum logic [1:0] {
    MODE_PLAIN  = 2'b00,
    MODE_DIRECT = 2'b01,
    MODE_HALF   = 2'b10,
    MODE_ROUND  = 2'b11
  } tally_mode_e;

  function automatic logic [DIGIT_W-1:0] bcd_next(input logic [DIGIT_W-1:0] v);
    return (v >= DIGIT_MAX) ? '0 : v + 1'b1;
  endfunction

endpackage

// File: rtl/tally_edge_sync.sv
module tally_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic step
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  // one pulse per rising edge of the synchronised level
  assign step = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tally_lead_decade.sv
module tally_lead_decade
  import bcd_tally_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               step,
  input  logic [1:0]         mode_sel,
  output logic [DIGIT_W-1:0] shown,
  output logic               carry
);
  logic [DIGIT_W-1:0] cnt_q;
  logic               adv;
  tally_mode_e        mode;

  assign mode = tally_mode_e'(mode_sel);

  always_comb begin
    adv   = step;
    carry = 1'b0;
    shown = '0;
    unique case (mode)
      MODE_PLAIN: begin
        carry = step && (cnt_q == DIGIT_MAX);
        shown = cnt_q;
      end
      MODE_DIRECT: begin
        // first decade frozen, input drives decade 1 directly
        adv   = 1'b0;
        carry = step;
      end
      MODE_ROUND: begin
        carry = step && (cnt_q == 4'd4);
      end
      MODE_HALF: begin
        carry = step && (cnt_q == 4'd7);
        shown = (cnt_q >= 4'd3 && cnt_q <= 4'd7) ? 4'd5 : 4'd0;
      end
      default: begin
        adv = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (adv)  cnt_q <= bcd_next(cnt_q);
  end
endmodule

// File: rtl/tally_decade.sv
module tally_decade
  import bcd_tally_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               cin,
  output logic [DIGIT_W-1:0] val,
  output logic               cout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    val <= '0;
    else if (clr)  val <= '0;
    else if (cin)  val <= bcd_next(val);
  end

  assign cout = cin && (val == DIGIT_MAX);
endmodule

// File: rtl/bcd_tally5.sv
module bcd_tally5
  import bcd_tally_pkg::*;
#(
  parameter int unsigned NDEC        = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    count_in,
  input  logic [1:0]              mode_sel,
  output logic [NDEC*DIGIT_W-1:0] digit_val,
  output logic                    carry_out
);
  localparam int unsigned TOTAL_W = NDEC * DIGIT_W;

  logic            step;
  logic [NDEC-1:0] chain_c;
  logic            wrap_q;

  tally_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (count_in),
    .step     (step)
  );

  tally_lead_decade u_lead (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .step     (step),
    .mode_sel (mode_sel),
    .shown    (digit_val[DIGIT_W-1:0]),
    .carry    (chain_c[0])
  );

  for (genvar g = 1; g < NDEC; g++) begin : g_dec
    tally_decade u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .cin   (chain_c[g-1]),
      .val   (digit_val[g*DIGIT_W +: DIGIT_W]),
      .cout  (chain_c[g])
    );
  end

  // wrap marker lives from one step to the next
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wrap_q <= 1'b0;
    else if (clr)   wrap_q <= 1'b0;
    else if (step)  wrap_q <= chain_c[NDEC-1];
  end

  assign carry_out = wrap_q | clr;

  initial begin
    if (TOTAL_W != NDEC * 4 || NDEC < 2 || SYNC_STAGES < 2)
      $display("bcd_tally5: unsupported parameters");
  end
endmodule

// File: rtl/tally_checker.sv
module tally_checker #(
  parameter int unsigned NDEC = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              step,
  input logic [1:0]        mode_sel,
  input logic [NDEC*4-1:0] digit_val,
  input logic              carry_out
);
  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> digit_val == '0);

  assert_hold_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(digit_val[NDEC*4-1:4]));

  for (genvar g = 1; g < NDEC; g++) begin : g_rng
    assert_digit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      digit_val[g*4 +: 4] <= 4'd9);
  end

  assert_lead_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel[0] |-> digit_val[3:0] == 4'd0);

  assert_half_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10) |-> (digit_val[3:0] == 4'd0 || digit_val[3:0] == 4'd5));

  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(carry_out) && !clr) |-> digit_val[NDEC*4-1:4] == '0);

  assert_wrap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_out && !clr && !step) |=> carry_out);

  assert_clear_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> carry_out);

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && step) |=> digit_val[NDEC*4-1:4] == '0);
endmodule

bind bcd_tally5 tally_checker #(.NDEC(NDEC)) u_tally_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .step      (step),
  .mode_sel  (mode_sel),
  .digit_val (digit_val),
  .carry_out (carry_out)
);

// File: tb/test_bcd_tally5.sv
module test_bcd_tally5;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        count_in = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic [19:0] digit_val;
  logic        carry_out;
  int n_run = 0;
  int n_fail = 0;

  bcd_tally5 i_bcd_tally5 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .count_in(count_in),
    .mode_sel(mode_sel), .digit_val(digit_val), .carry_out(carry_out)
  );

  always #10 clk = ~clk;

  function automatic int dig(input int i);
    return int'(digit_val[4*i +: 4]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) count_in = 1'b1;
      repeat (2) @(negedge clk);
      count_in = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic clear_all();
    @(negedge clk) clr = 1'b1;
    @(negedge clk);
    chk("R9 carry during clear", int'(carry_out), 1);
    clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset digits", int'(digit_val), 0);
    chk("R1 reset carry", int'(carry_out), 0);
  endtask

  task automatic t_long_high();
    mode_sel = 2'b00;
    clear_all();
    @(negedge clk) count_in = 1'b1;
    repeat (12) @(negedge clk);
    chk("R2 held input one step", dig(0), 1);
    count_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 after release", dig(0), 1);
  endtask

  task automatic t_plain();
    mode_sel = 2'b00;
    clear_all();
    pulse(9);
    chk("R3 units at 9", dig(0), 9);
    chk("R3 tens before carry", dig(1), 0);
    pulse(3);
    chk("R3 units after wrap", dig(0), 2);
    chk("R3 tens after wrap", dig(1), 1);
    pulse(187);
    chk("R4 units 199", dig(0), 9);
    chk("R4 tens 199", dig(1), 9);
    chk("R4 hundreds 199", dig(2), 1);
    pulse(1);
    chk("R4 tens rolls to 0", dig(1), 0);
    chk("R4 hundreds advance", dig(2), 2);
    chk("R8 no wrap marker", int'(carry_out), 0);
  endtask

  task automatic t_direct();
    mode_sel = 2'b01;
    clear_all();
    pulse(3);
    chk("R5 units blank", dig(0), 0);
    chk("R5 tens direct", dig(1), 3);
  endtask

  task automatic t_round();
    mode_sel = 2'b11;
    clear_all();
    pulse(4);
    chk("R6 tens before 4-to-5", dig(1), 0);
    chk("R6 units blank", dig(0), 0);
    pulse(1);
    chk("R6 tens at 4-to-5", dig(1), 1);
    pulse(10);
    chk("R6 tens second carry", dig(1), 2);
    chk("R6 units still blank", dig(0), 0);
  endtask

  task automatic t_half();
    mode_sel = 2'b10;
    clear_all();
    pulse(2);
    chk("R7 shows 0 at count 2", dig(0), 0);
    pulse(1);
    chk("R7 shows 5 at count 3", dig(0), 5);
    pulse(4);
    chk("R7 shows 5 at count 7", dig(0), 5);
    chk("R7 no carry yet", dig(1), 0);
    pulse(1);
    chk("R7 shows 0 at count 8", dig(0), 0);
    chk("R7 carry at 7-to-8", dig(1), 1);
  endtask

  task automatic t_clear_vs_step();
    mode_sel = 2'b00;
    clear_all();
    pulse(4);
    @(negedge clk) count_in = 1'b1;
    @(negedge clk) clr = 1'b1;
    @(negedge clk);
    chk("R10 digits during clash", int'(digit_val), 0);
    chk("R9 carry during clash", int'(carry_out), 1);
    @(negedge clk) clr = 1'b0;
    count_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 no late step", int'(digit_val), 0);
    chk("R1 carry after clear", int'(carry_out), 0);
  endtask

  task automatic t_wrap();
    mode_sel = 2'b01;
    clear_all();
    pulse(9999);
    chk("R8 tens 9", dig(1), 9);
    chk("R8 top 9", dig(4), 9);
    chk("R8 carry low before wrap", int'(carry_out), 0);
    pulse(1);
    chk("R8 all zero at wrap", int'(digit_val), 0);
    chk("R8 carry at wrap", int'(carry_out), 1);
    repeat (3) @(negedge clk);
    chk("R8 carry held", int'(carry_out), 1);
    pulse(1);
    chk("R8 carry drops", int'(carry_out), 0);
    chk("R8 tens after wrap", dig(1), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_long_high();
    t_plain();
    t_direct();
    t_round();
    t_half();
    t_clear_vs_step();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule